// File: doc/BRIEF.md
# Push-Pull Gate Drive Steering Core

This block is the digital heart of a two-channel power switch driver. A single pulse-width command arrives on a pair of logic inputs: one active low, one active high. The block turns it into two registered drive enables, `drv_a` and `drv_b`, which feed external output stages. A mode input picks between two behaviours. In alternating mode, a steering flip-flop sends each new command pulse to the other channel, which turns a single-ended modulator into a push-pull drive. In parallel mode, both channels follow the command together, so the two stages can be tied together for more current.

Several protection paths can hold the enables low. A fast-stop request latches off the rest of the current pulse. A per-channel inhibit keeps one side off while the opposite switch is still conducting. An over-temperature flag and a supply-good flag gate both channels. The stop latch and the steering flip-flop change state only after the command has been idle for a minimum off-time. As a result, a short gap does not count as a new pulse, and a stop event lasts for exactly one pulse. The stop, inhibit, temperature and supply flags are asynchronous, so each passes through a synchroniser before use.

Top module: `gate_steer_core`

## Requirements
- R1: The command is active only when `cmd_inv` = 0 and `cmd_pos` = 1. The other three input combinations leave both outputs low.
- R2: With `alt_en` = 1, each command pulse drives exactly one output. Successive pulses alternate between channels, and the first pulse after reset goes to `drv_a`.
- R3: With `alt_en` = 0, `drv_a` and `drv_b` both follow the command.
- R4: The steering flip-flop toggles at most once per pulse, and only after the command has been inactive for `OFF_CYC` consecutive cycles. A pulse that follows a shorter gap goes to the same channel as the one before it.
- R5: A synchronised `stop_req` forces both outputs low from that point and latches, holding them low for the rest of the pulse.
- R6: The stop latch clears only after the command has been inactive for `OFF_CYC` cycles. A pulse after a shorter gap stays blocked; a pulse after a long enough gap drives again.
- R7: While `inhib_a` is asserted, `drv_a` stays low even when it is selected and commanded. `inhib_b` acts the same way on `drv_b`.
- R8: While `over_temp` is asserted, both outputs are low whatever the other inputs are.
- R9: While `supply_ok` is deasserted, both outputs are low.
- R10: Both outputs are registered. A change on the command inputs reaches the outputs one clock later. A change on a synchronised flag (stop, inhibit, temperature, supply) reaches the outputs three clocks later.
- R11: During and right after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_inv | input | 1 | Command input, active low (synchronous) |
| cmd_pos | input | 1 | Command input, active high (synchronous) |
| alt_en | input | 1 | 1 = alternating steering, 0 = parallel drive |
| stop_req | input | 1 | Asynchronous fast-stop request, sets the stop latch |
| inhib_a | input | 1 | Asynchronous: opposite switch of channel A still on |
| inhib_b | input | 1 | Asynchronous: opposite switch of channel B still on |
| over_temp | input | 1 | Asynchronous over-temperature flag (hysteresis applied outside) |
| supply_ok | input | 1 | Asynchronous supply-good flag |
| drv_a | output | 1 | Registered drive enable, channel A |
| drv_b | output | 1 | Registered drive enable, channel B |

## Verification
Four trains of alternating-mode pulses separated by long gaps show that the channel alternates and that reset selects A first. A train with a gap shorter than `OFF_CYC` shows that double-pulse suppression works, because the same channel must repeat. Three stop-related pulses tell latching apart from clearing:
- a stop mid-pulse;
- a follow-up pulse after a short gap;
- a follow-up pulse after a long gap.

Parallel pulses show that both outputs are driven. The same pulses with one inhibit, with over-temperature, or with the supply flag lost show which gate acts on which channel. All three non-active command encodings are also applied. A behavioural model with queued flag delays is compared with both outputs on every cycle, which pins down the one-cycle and three-cycle latencies.

// File: rtl/gate_steer_pkg.sv
// Shared constants for the push-pull steering core.
// Assumes: flags are grouped into one vector in the order given here.
package gate_steer_pkg;
    localparam int FLG_STOP  = 0;
    localparam int FLG_INH_A = 1;
    localparam int FLG_INH_B = 2;
    localparam int FLG_HOT   = 3;
    localparam int FLG_PWR   = 4;
    localparam int NUM_FLG   = 5;
    localparam int NUM_CH    = 2;
endpackage

// File: rtl/gs_sync.sv
// Multi-stage synchroniser for a vector of asynchronous flags.
// Assumes: STAGES >= 2; every flag resets to 0 (its safe value).
module gs_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw flags through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gs_offtime.sv
// Counts consecutive idle command cycles, saturating at OFF_CYC.
// off_done is high once the command has been idle long enough.
// Assumes: out of reset the off-time already counts as elapsed.
module gs_offtime #(
    parameter int OFF_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    output logic off_done
);
    localparam int CNT_W = $clog2(OFF_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OFF_CYC);

    logic [CNT_W-1:0] idle_cnt;

    // Restart on an active command, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)               idle_cnt <= LIMIT;
        else if (cmd)             idle_cnt <= '0;
        else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign off_done = (idle_cnt == LIMIT);
endmodule

// File: rtl/gs_steer.sv
// Steering flip-flop with double-pulse suppression, and the stop latch.
// The flip-flop toggles once per used pulse, after the off-time has elapsed.
// The stop latch sets on a stop flag and clears after the off-time.
// Assumes: stop_s is already synchronised; off_done comes from gs_offtime.
module gs_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic alt_en,
    input  logic off_done,
    input  logic stop_s,
    output logic sel_b,
    output logic stop_lat
);
    logic pulse_used;

    // Mark a pulse as consumed, then toggle the channel once the gap is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_b      <= 1'b0;
            pulse_used <= 1'b0;
        end else if (cmd && alt_en) begin
            pulse_used <= 1'b1;
        end else if (!cmd && off_done && pulse_used) begin
            pulse_used <= 1'b0;
            sel_b      <= ~sel_b;
        end
    end

    // Set the stop latch; set takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        stop_lat <= 1'b0;
        else if (stop_s)   stop_lat <= 1'b1;
        else if (off_done) stop_lat <= 1'b0;
    end
endmodule

// File: rtl/gate_steer_core.sv
// Top of the push-pull steering core. Decodes the command, steers it to
// one or both channels, applies every protection gate and registers the outputs.
// Assumes: cmd_inv/cmd_pos are synchronous to clk; the other flags are asynchronous.
module gate_steer_core #(
    parameter int OFF_CYC     = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_inv,
    input  logic cmd_pos,
    input  logic alt_en,
    input  logic stop_req,
    input  logic inhib_a,
    input  logic inhib_b,
    input  logic over_temp,
    input  logic supply_ok,
    output logic drv_a,
    output logic drv_b
);
    import gate_steer_pkg::*;

    logic [NUM_FLG-1:0] flg_raw, flg_s;
    logic               cmd, off_done, sel_b, stop_lat, kill;
    logic [NUM_CH-1:0]  inh_s, drv_q;

    assign flg_raw[FLG_STOP]  = stop_req;
    assign flg_raw[FLG_INH_A] = inhib_a;
    assign flg_raw[FLG_INH_B] = inhib_b;
    assign flg_raw[FLG_HOT]   = over_temp;
    assign flg_raw[FLG_PWR]   = supply_ok;

    gs_sync #(.WIDTH(NUM_FLG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(flg_raw), .dout(flg_s)
    );

    assign cmd = cmd_pos & ~cmd_inv;

    gs_offtime #(.OFF_CYC(OFF_CYC)) u_off (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .off_done(off_done)
    );

    gs_steer u_steer (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .alt_en(alt_en),
        .off_done(off_done), .stop_s(flg_s[FLG_STOP]),
        .sel_b(sel_b), .stop_lat(stop_lat)
    );

    assign kill     = flg_s[FLG_STOP] | stop_lat | flg_s[FLG_HOT] | ~flg_s[FLG_PWR];
    assign inh_s[0] = flg_s[FLG_INH_A];
    assign inh_s[1] = flg_s[FLG_INH_B];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic picked;
        assign picked = alt_en ? (sel_b == ch[0]) : 1'b1;

        // Register this channel's gated drive enable.
        always_ff @(posedge clk) begin
            if (!rst_n) drv_q[ch] <= 1'b0;
            else        drv_q[ch] <= cmd & picked & ~inh_s[ch] & ~kill;
        end
    end

    assign drv_a = drv_q[0];
    assign drv_b = drv_q[1];
endmodule

// File: rtl/gate_steer_chk.sv
// Checker for gate_steer_core, attached with bind. Looks at ports only.
// Assumes the default two-stage synchroniser (flag to output = 3 clocks).
module gate_steer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_inv,
    input logic cmd_pos,
    input logic alt_en,
    input logic stop_req,
    input logic inhib_a,
    input logic inhib_b,
    input logic over_temp,
    input logic supply_ok,
    input logic drv_a,
    input logic drv_b
);
    logic [1:0] warm_cnt;
    logic       warm;

    // Count cycles since reset so flag-latency checks skip the pre-reset history.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 1'b1;
    end
    assign warm = (warm_cnt == 2'd3);

    a_r1_cmd_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a || drv_b) |-> $past(cmd_pos && !cmd_inv));

    a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a && drv_b) |-> $past(!alt_en));

    a_r5_stop_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(stop_req, 3)) |-> (!drv_a && !drv_b));

    a_r7_inhibit_a: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(inhib_a, 3)) |-> !drv_a);

    a_r7_inhibit_b: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(inhib_b, 3)) |-> !drv_b);

    a_r8_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(over_temp, 3)) |-> (!drv_a && !drv_b));

    a_r9_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(!supply_ok, 3)) |-> (!drv_a && !drv_b));

    a_r11_reset_low: assert property (@(posedge clk)
        $past(!rst_n) |-> (!drv_a && !drv_b));
endmodule

bind gate_steer_core gate_steer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_inv(cmd_inv), .cmd_pos(cmd_pos),
    .alt_en(alt_en), .stop_req(stop_req), .inhib_a(inhib_a), .inhib_b(inhib_b),
    .over_temp(over_temp), .supply_ok(supply_ok), .drv_a(drv_a), .drv_b(drv_b)
);

// File: tb/gate_steer_core_bench.sv
module gate_steer_core_bench;
    localparam int OFF = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_inv = 1'b1, cmd_pos = 1'b0, alt_en = 1'b1;
    logic stop_req = 1'b0, inhib_a = 1'b0, inhib_b = 1'b0;
    logic over_temp = 1'b0, supply_ok = 1'b0;
    logic drv_a, drv_b;

    int    n_run = 0, n_fail = 0;
    int    hits_a = 0, hits_b = 0;
    string tag = "R11";
    bit    cmp_on = 0;

    always #4 clk = ~clk;

    gate_steer_core #(.OFF_CYC(OFF)) u_gate_steer_core (
        .clk(clk), .rst_n(rst_n), .cmd_inv(cmd_inv), .cmd_pos(cmd_pos),
        .alt_en(alt_en), .stop_req(stop_req), .inhib_a(inhib_a), .inhib_b(inhib_b),
        .over_temp(over_temp), .supply_ok(supply_ok), .drv_a(drv_a), .drv_b(drv_b)
    );

    // Behavioural reference: flag delays are queues, the state is held in integers.
    bit [4:0] flag_q[$];
    int  idle = OFF, chan = 0, consumed = 0, stopped = 0;
    bit  exp_a = 0, exp_b = 0;

    initial begin flag_q.push_back(5'b0); flag_q.push_back(5'b0); end

    always @(posedge clk) begin
        bit [4:0] f;
        bit c, blk;
        if (!rst_n) begin
            flag_q = {5'b0, 5'b0};
            idle = OFF; chan = 0; consumed = 0; stopped = 0;
            exp_a = 0; exp_b = 0;
        end else begin
            f = flag_q.pop_front();
            flag_q.push_back({supply_ok, over_temp, inhib_b, inhib_a, stop_req});
            c   = (cmd_inv == 1'b0) && (cmd_pos == 1'b1);
            blk = f[0] || (stopped != 0) || f[3] || !f[4];
            exp_a = c && !blk && !f[1] && (!alt_en || chan == 0);
            exp_b = c && !blk && !f[2] && (!alt_en || chan == 1);
            if (f[0]) stopped = 1;
            else if (idle >= OFF) stopped = 0;
            if (c && alt_en) consumed = 1;
            else if (!c && idle >= OFF && consumed != 0) begin
                consumed = 0; chan = 1 - chan;
            end
            if (c) idle = 0;
            else if (idle < OFF) idle++;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            n_run++;
            if (drv_a !== exp_a || drv_b !== exp_b) begin
                n_fail++;
                $display("FAIL %s cycle compare: actual a=%0b b=%0b expected a=%0b b=%0b",
                         tag, drv_a, drv_b, exp_a, exp_b);
            end
            hits_a += int'(drv_a);
            hits_b += int'(drv_b);
        end
    end

    task automatic pulse(input int len, input int gap);
        cmd_inv = 1'b0; cmd_pos = 1'b1;
        repeat (len) @(negedge clk);
        cmd_inv = 1'b1; cmd_pos = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic expect_hits(input string t, input int ea, input int eb);
        n_run++;
        if (hits_a != ea || hits_b != eb) begin
            n_fail++;
            $display("FAIL %s pulse hits: actual a=%0d b=%0d expected a=%0d b=%0d",
                     t, hits_a, hits_b, ea, eb);
        end
        hits_a = 0; hits_b = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        n_run++;                                   // R11 reset state
        if (drv_a !== 1'b0 || drv_b !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: actual a=%0b b=%0b expected a=0 b=0", drv_a, drv_b);
        end
        rst_n = 1'b1; cmp_on = 1;
        supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        hits_a = 0; hits_b = 0;

        tag = "R1";                                // non-active encodings
        cmd_inv = 1'b1; cmd_pos = 1'b1; repeat (4) @(negedge clk);
        cmd_inv = 1'b0; cmd_pos = 1'b0; repeat (4) @(negedge clk);
        cmd_inv = 1'b1; cmd_pos = 1'b0; repeat (4) @(negedge clk);
        expect_hits("R1", 0, 0);

        tag = "R2";                                // alternation, A first
        pulse(4, 30); expect_hits("R2", 4, 0);
        pulse(4, 30); expect_hits("R2", 0, 4);
        pulse(4, 30); expect_hits("R2", 4, 0);
        pulse(4, 30); expect_hits("R2", 0, 4);

        tag = "R4";                                // short gap: no toggle
        pulse(4, 10); expect_hits("R4", 4, 0);
        pulse(4, 30); expect_hits("R4", 4, 0);
        pulse(4, 30); expect_hits("R4", 0, 4);

        tag = "R3";                                // parallel drive
        alt_en = 1'b0;
        pulse(5, 30); expect_hits("R3", 5, 5);

        tag = "R10";                               // one-cycle command latency
        cmd_inv = 1'b0; cmd_pos = 1'b1;
        @(negedge clk);
        n_run++;
        if (drv_a !== 1'b1 || drv_b !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 latency: actual a=%0b b=%0b expected a=1 b=1", drv_a, drv_b);
        end
        repeat (3) @(negedge clk);
        cmd_inv = 1'b1; cmd_pos = 1'b0;
        repeat (30) @(negedge clk);
        hits_a = 0; hits_b = 0;

        tag = "R5";                                // stop mid-pulse
        alt_en = 1'b1;
        cmd_inv = 1'b0; cmd_pos = 1'b1;
        repeat (2) @(negedge clk);
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        repeat (7) @(negedge clk);
        cmd_inv = 1'b1; cmd_pos = 1'b0;
        repeat (10) @(negedge clk);
        n_run++;
        if (hits_a + hits_b != 4) begin
            n_fail++;
            $display("FAIL R5 stopped pulse: actual hits=%0d expected 4", hits_a + hits_b);
        end
        hits_a = 0; hits_b = 0;
        tag = "R6";
        pulse(4, 30); expect_hits("R6", 0, 0);
        pulse(4, 30);
        n_run++;
        if (hits_a + hits_b != 4) begin
            n_fail++;
            $display("FAIL R6 release: actual hits=%0d expected 4", hits_a + hits_b);
        end
        hits_a = 0; hits_b = 0;

        tag = "R7";                                // inhibit per channel
        alt_en = 1'b0;
        inhib_a = 1'b1; repeat (4) @(negedge clk);
        pulse(4, 5); expect_hits("R7", 0, 4);
        inhib_a = 1'b0; inhib_b = 1'b1; repeat (4) @(negedge clk);
        pulse(4, 5); expect_hits("R7", 4, 0);
        inhib_b = 1'b0; repeat (4) @(negedge clk);

        tag = "R8";
        over_temp = 1'b1; repeat (4) @(negedge clk);
        pulse(4, 5); expect_hits("R8", 0, 0);
        over_temp = 1'b0; repeat (4) @(negedge clk);

        tag = "R9";
        supply_ok = 1'b0; repeat (4) @(negedge clk);
        pulse(4, 5); expect_hits("R9", 0, 0);
        supply_ok = 1'b1; repeat (4) @(negedge clk);
        pulse(4, 5); expect_hits("R9", 4, 4);

        cmp_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule